// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits on the transmit side of a packet link and decides, one candidate packet at a time, whether the link partner has room for it. The partner's buffer space is tracked in six pools: a header pool and a data pool for each of three traffic categories (posted requests, non-posted requests and completions). At link-up the partner's first advertisement loads every pool's limit. While the link runs, parsed update messages raise a category's limits as the partner frees buffer space. A packet descriptor gives the category, whether a header is present and the payload length in bytes. Data is charged in 16-byte units, and any part of a unit counts as a whole unit.

A grant is registered. It appears one cycle after the descriptor is presented. On that same clock edge the consumed counters of every pool the packet touches advance. Counters and limits are modular: header values are 8 bits and data values are 12 bits. The limit check looks at the modular distance between the limit and the would-be consumed value, so a counter wrapping past zero never blocks or passes a packet wrongly. A pool whose initial advertisement is zero has infinite credit and always passes. An endpoint partner advertises its completion pools this way.

Top module: `fc_credit_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `grant_o` is 0 and all six consumed counters read 0.
- R2: No packet is granted until an initial advertisement has been loaded with `init_valid_i`. Loading clears all consumed counters and replaces all limits. A request in the loading cycle is not granted.
- R3: A packet's data need is ceil(bytes/16) units. A packet with zero payload bytes takes no data credit, and its category's data pool is not checked.
- R4: A packet with `req_has_hdr_i` = 1 needs exactly one header credit. A packet with `req_has_hdr_i` = 0 takes no header credit and leaves its header pool unchecked.
- R5: A request presented in cycle t is granted (`grant_o` = 1 in cycle t+1) only if every pool it touches satisfies (limit − (consumed + need)) mod 2^N ≤ 2^(N−1). N is 8 for header pools and 12 for data pools, and the state used is the state before the edge.
- R6: Consumed counters change only on the edge that produces a grant (or a load). A refused request leaves every counter unchanged.
- R7: Consumed counters and limits wrap modulo 2^N. Grants continue correctly across the wrap.
- R8: A pool whose initial advertised value is 0 is infinite and always passes its check. Its consumed counter still advances modulo 2^N.
- R9: An update (`upd_valid_i`) replaces the header and data limits of category `upd_cat_i`. The new limit is first used by a request presented in the next cycle. Updates to an infinite pool are ignored.
- R10: Category encoding is 0 = posted, 1 = non-posted, 2 = completion. A request with category 3 is never granted. An update with category 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid_i | input | 1 | Load the initial advertisement for all six pools |
| init_hdr_i | input | 3*HDR_W | Initial header limits; category c in bits [c*HDR_W +: HDR_W]; 0 = infinite |
| init_dat_i | input | 3*DAT_W | Initial data limits; category c in bits [c*DAT_W +: DAT_W]; 0 = infinite |
| upd_valid_i | input | 1 | A parsed limit update is present |
| upd_cat_i | input | 2 | Category of the update |
| upd_hdr_i | input | HDR_W | New header limit |
| upd_dat_i | input | DAT_W | New data limit |
| req_valid_i | input | 1 | A candidate packet descriptor is present |
| req_cat_i | input | 2 | Category of the candidate |
| req_has_hdr_i | input | 1 | Candidate carries a header |
| req_bytes_i | input | LEN_W | Candidate payload length in bytes |
| grant_o | output | 1 | Registered grant for the previous cycle's candidate |
| cons_hdr_o | output | 3*HDR_W | Consumed header counters, same packing as init_hdr_i |
| cons_dat_o | output | 3*DAT_W | Consumed data counters, same packing as init_dat_i |

## Verification
The consumed counters are outputs, so a wrong charge shows up at the ports on the very next cycle. Examples are an off-by-one round-up, a header charged on a headerless packet, or a pool charged on a refusal. The bench's cycle-by-cycle model catches all of these at once. A corrupted limit or a wrong infinite flag is invisible until a request lands near the boundary. So the bench walks the pools to exact exhaustion, one unit short and one unit over. It then forces the counters through many wraps with moving limits, so a faulty comparison shows up as a wrong `grant_o` within one cycle of the request that crosses it.

// File: rtl/fc_gate_pkg.sv
package fc_gate_pkg;
  localparam int NUM_CAT = 3;

  typedef enum logic [1:0] {
    CAT_POSTED    = 2'd0,
    CAT_NONPOSTED = 2'd1,
    CAT_CPL       = 2'd2,
    CAT_RSVD      = 2'd3
  } fc_cat_e;
endpackage

// File: rtl/fc_data_units.sv
// Payload bytes to data credit units, rounded up.
module fc_data_units #(
  parameter int LEN_W = 13,
  parameter int DAT_W = 12,
  parameter int SHIFT = 4
) (
  input  logic [LEN_W-1:0] bytes_i,
  output logic [DAT_W-1:0] units_o
);
  localparam logic [LEN_W:0] PAD = (LEN_W+1)'((1 << SHIFT) - 1);

  logic [LEN_W:0] padded;

  always_comb begin
    padded  = {1'b0, bytes_i} + PAD;
    units_o = DAT_W'(padded >> SHIFT);
  end

  // R3: the unit count covers the payload and wastes less than one unit
  always_comb begin
    a_r3_round_up: assert ((int'(units_o) << SHIFT) >= int'(bytes_i) &&
                           (int'(units_o) << SHIFT) <  int'(bytes_i) + (1 << SHIFT));
  end
endmodule

// File: rtl/fc_pool.sv
// One credit pool: limit, consumed counter, infinite flag and modular check.
module fc_pool #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_en,
  input  logic [W-1:0] init_val,
  input  logic         upd_en,
  input  logic [W-1:0] upd_val,
  input  logic [W-1:0] need,
  input  logic         take,
  output logic         ok,
  output logic [W-1:0] cons_o
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] lim;
  logic [W-1:0] cons;
  logic         inf;
  logic [W-1:0] after;
  logic [W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim  <= '0;
      cons <= '0;
      inf  <= 1'b0;
    end else if (init_en) begin
      lim  <= init_val;
      inf  <= (init_val == '0);
      cons <= '0;
    end else begin
      if (upd_en && !inf) lim <= upd_val;
      if (take)           cons <= cons + need;
    end
  end

  always_comb begin
    after = cons + need;
    gap   = lim - after;
    ok    = inf || (gap <= HALF);
  end

  assign cons_o = cons;

  // R6: counter holds unless a grant or a load touches it
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!take && !init_en) |=> $stable(cons));

  // R6, R7: a grant advances the counter by the need, modulo 2^W
  a_r7_advance: assert property (@(posedge clk) disable iff (rst)
    (take && !init_en) |=> (cons == W'($past(cons) + $past(need))));

  // R2: a load clears the counter
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    init_en |=> (cons == '0));

  // R9: an infinite pool ignores updates
  a_r9_inf_frozen: assert property (@(posedge clk) disable iff (rst)
    (inf && !init_en) |=> $stable(lim));
endmodule

// File: rtl/fc_credit_gate.sv
// Transmit credit gate: six pools, registered grant.
module fc_credit_gate
  import fc_gate_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12,
  parameter int LEN_W = 13,
  parameter int UNIT_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init_valid_i,
  input  logic [NUM_CAT*HDR_W-1:0] init_hdr_i,
  input  logic [NUM_CAT*DAT_W-1:0] init_dat_i,
  input  logic                     upd_valid_i,
  input  logic [1:0]               upd_cat_i,
  input  logic [HDR_W-1:0]         upd_hdr_i,
  input  logic [DAT_W-1:0]         upd_dat_i,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_cat_i,
  input  logic                     req_has_hdr_i,
  input  logic [LEN_W-1:0]         req_bytes_i,
  output logic                     grant_o,
  output logic [NUM_CAT*HDR_W-1:0] cons_hdr_o,
  output logic [NUM_CAT*DAT_W-1:0] cons_dat_o
);
  localparam logic [HDR_W-1:0] ONE_HDR = HDR_W'(1);

  logic [DAT_W-1:0]   units;
  logic               ready;
  logic               allow;
  logic [NUM_CAT-1:0] touch_h, touch_d, ok_h, ok_d, upd_sel;

  fc_data_units #(.LEN_W(LEN_W), .DAT_W(DAT_W), .SHIFT(UNIT_SHIFT)) units_i (
    .bytes_i (req_bytes_i),
    .units_o (units)
  );

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    always_comb begin
      touch_h[c] = req_valid_i && (req_cat_i == 2'(c)) && req_has_hdr_i;
      touch_d[c] = req_valid_i && (req_cat_i == 2'(c)) && (units != '0);
      upd_sel[c] = upd_valid_i && (upd_cat_i == 2'(c));
    end

    fc_pool #(.W(HDR_W)) hdr_pool_i (
      .clk      (clk),
      .rst      (rst),
      .init_en  (init_valid_i),
      .init_val (init_hdr_i[c*HDR_W +: HDR_W]),
      .upd_en   (upd_sel[c]),
      .upd_val  (upd_hdr_i),
      .need     (ONE_HDR),
      .take     (allow && touch_h[c]),
      .ok       (ok_h[c]),
      .cons_o   (cons_hdr_o[c*HDR_W +: HDR_W])
    );

    fc_pool #(.W(DAT_W)) dat_pool_i (
      .clk      (clk),
      .rst      (rst),
      .init_en  (init_valid_i),
      .init_val (init_dat_i[c*DAT_W +: DAT_W]),
      .upd_en   (upd_sel[c]),
      .upd_val  (upd_dat_i),
      .need     (units),
      .take     (allow && touch_d[c]),
      .ok       (ok_d[c]),
      .cons_o   (cons_dat_o[c*DAT_W +: DAT_W])
    );
  end

  always_comb begin
    allow = req_valid_i && ready && !init_valid_i &&
            (req_cat_i != CAT_RSVD) &&
            (&(~touch_h | ok_h)) && (&(~touch_d | ok_d));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      grant_o <= 1'b0;
    end else begin
      if (init_valid_i) ready <= 1'b1;
      grant_o <= allow;
    end
  end

  // R2: nothing is granted before the first load
  a_r2_no_grant_unready: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !grant_o);

  // R10: reserved category is never granted
  a_r10_rsvd_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_cat_i == CAT_RSVD) |=> !grant_o);

  // R5: a grant always answers a request of the previous cycle
  a_r5_grant_has_req: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(req_valid_i));

  // R6: at most one category's pools are charged per cycle
  a_r6_one_category: assert property (@(posedge clk) disable iff (rst)
    $onehot0(touch_h | touch_d));
endmodule

// File: tb/fc_credit_gate_tb_top.sv
`timescale 1ns/1ps
module fc_credit_gate_tb_top;
  localparam int HW = 8;
  localparam int DW = 12;
  localparam int LW = 13;
  localparam int HM = 256;
  localparam int DM = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_valid_i = 1'b0;
  logic [3*HW-1:0] init_hdr_i = '0;
  logic [3*DW-1:0] init_dat_i = '0;
  logic upd_valid_i = 1'b0;
  logic [1:0] upd_cat_i = '0;
  logic [HW-1:0] upd_hdr_i = '0;
  logic [DW-1:0] upd_dat_i = '0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_cat_i = '0;
  logic req_has_hdr_i = 1'b0;
  logic [LW-1:0] req_bytes_i = '0;
  logic grant_o;
  logic [3*HW-1:0] cons_hdr_o;
  logic [3*DW-1:0] cons_dat_o;

  always #2.5 clk = ~clk;

  fc_credit_gate dut_i (
    .clk(clk), .rst(rst),
    .init_valid_i(init_valid_i), .init_hdr_i(init_hdr_i), .init_dat_i(init_dat_i),
    .upd_valid_i(upd_valid_i), .upd_cat_i(upd_cat_i), .upd_hdr_i(upd_hdr_i), .upd_dat_i(upd_dat_i),
    .req_valid_i(req_valid_i), .req_cat_i(req_cat_i), .req_has_hdr_i(req_has_hdr_i),
    .req_bytes_i(req_bytes_i),
    .grant_o(grant_o), .cons_hdr_o(cons_hdr_o), .cons_dat_o(cons_dat_o)
  );

  // reference model: index c = header pool, 3+c = data pool
  int lim [6];
  int cons [6];
  bit inf [6];
  bit ready_m;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic int pmod(int a, int m);
    return ((a % m) + m) % m;
  endfunction

  function automatic bit pool_ok(int p, int need);
    int m = (p < 3) ? HM : DM;
    if (inf[p]) return 1'b1;
    return pmod(lim[p] - cons[p] - need, m) <= m / 2;
  endfunction

  task automatic check_all(string tag, bit eg);
    bit bad = (grant_o !== eg);
    for (int c = 0; c < 3; c++) begin
      if (int'(cons_hdr_o[c*HW +: HW]) != cons[c]) bad = 1'b1;
      if (int'(cons_dat_o[c*DW +: DW]) != cons[3+c]) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: grant=%0b hdr=%h dat=%h expected grant=%0b hdr=%0d/%0d/%0d dat=%0d/%0d/%0d",
               tag, grant_o, cons_hdr_o, cons_dat_o, eg, cons[0], cons[1], cons[2],
               cons[3], cons[4], cons[5]);
    end
  endtask

  // one clock: compute expected from current inputs, step, compare
  task automatic cycle(string tag);
    int units = (int'(req_bytes_i) + 15) / 16;
    int c = int'(req_cat_i);
    bit g = 1'b0;
    if (!rst && !init_valid_i && ready_m && req_valid_i && c < 3) begin
      g = 1'b1;
      if (req_has_hdr_i && !pool_ok(c, 1)) g = 1'b0;
      if (units > 0 && !pool_ok(3 + c, units)) g = 1'b0;
    end
    if (rst) begin
      ready_m = 1'b0;
      for (int p = 0; p < 6; p++) begin lim[p] = 0; cons[p] = 0; inf[p] = 1'b0; end
    end else if (init_valid_i) begin
      ready_m = 1'b1;
      for (int k = 0; k < 3; k++) begin
        lim[k] = int'(init_hdr_i[k*HW +: HW]);
        lim[3+k] = int'(init_dat_i[k*DW +: DW]);
        inf[k] = (lim[k] == 0);
        inf[3+k] = (lim[3+k] == 0);
        cons[k] = 0; cons[3+k] = 0;
      end
    end else begin
      if (g) begin
        if (req_has_hdr_i) cons[c] = pmod(cons[c] + 1, HM);
        if (units > 0) cons[3+c] = pmod(cons[3+c] + units, DM);
      end
      if (upd_valid_i && upd_cat_i != 2'd3) begin
        if (!inf[upd_cat_i]) lim[upd_cat_i] = int'(upd_hdr_i);
        if (!inf[3+upd_cat_i]) lim[3+upd_cat_i] = int'(upd_dat_i);
      end
    end
    @(posedge clk);
    #1;
    check_all(tag, g);
  endtask

  task automatic idle();
    init_valid_i = 1'b0; upd_valid_i = 1'b0; req_valid_i = 1'b0;
  endtask

  task automatic req(int cat, bit hh, int bytes);
    req_valid_i = 1'b1; req_cat_i = 2'(cat); req_has_hdr_i = hh; req_bytes_i = LW'(bytes);
  endtask

  task automatic upd(int cat, int h, int d);
    upd_valid_i = 1'b1; upd_cat_i = 2'(cat); upd_hdr_i = HW'(h); upd_dat_i = DW'(d);
  endtask

  task automatic load(int ph, int pd, int nh, int nd, int ch, int cd);
    init_valid_i = 1'b1;
    init_hdr_i = {HW'(ch), HW'(nh), HW'(ph)};
    init_dat_i = {DW'(cd), DW'(nd), DW'(pd)};
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    cycle("R1"); cycle("R1"); cycle("R1");
    rst = 1'b0;
    cycle("R1");
    // R2: refused before any load
    req(0, 1'b1, 16); cycle("R2");
    // R2: load in same cycle as a request is not granted
    load(4, 8, 2, 1, 0, 0); cycle("R2");
    idle();
    // R3: 100 bytes -> 7 units, R4 one header
    req(0, 1'b1, 100); cycle("R3");
    // R5/R6: 32 bytes needs 2, only 1 left -> refused, counters hold
    req(0, 1'b1, 32); cycle("R6");
    // R5: 16 bytes exactly exhausts data pool
    req(0, 1'b1, 16); cycle("R5");
    // R3: zero payload leaves exhausted data pool unchecked
    req(0, 1'b1, 0); cycle("R3");
    // R4: headerless packet with 1 byte -> data check fails (pool full)
    req(0, 1'b0, 1); cycle("R4");
    // R4: headerless zero-length packet touches nothing, granted
    req(0, 1'b0, 0); cycle("R4");
    // R5: posted header pool: 3 used of 4, one more ok then refused
    req(0, 1'b1, 0); cycle("R5");
    req(0, 1'b1, 0); cycle("R5");
    // R5: non-posted header limit 2
    req(1, 1'b1, 0); cycle("R5");
    req(1, 1'b1, 0); cycle("R5");
    req(1, 1'b1, 0); cycle("R5");
    // R5: non-posted data limit 1 unit: 17 bytes refused
    idle(); upd(1, 3, 1); cycle("R9");
    idle(); req(1, 1'b1, 17); cycle("R5");
    // R8: completions infinite
    req(2, 1'b1, 4096); cycle("R8");
    req(2, 1'b1, 4096); cycle("R8");
    // R9: updates to infinite pools ignored
    idle(); upd(2, 1, 1); cycle("R9");
    idle(); req(2, 1'b1, 4096); cycle("R9");
    // R9: same-cycle update uses old limit, next cycle new limit
    upd(0, 20, 20); req(0, 1'b1, 16); cycle("R9");
    idle(); req(0, 1'b1, 16); cycle("R9");
    // R10: reserved category refused, reserved update ignored
    req(3, 1'b1, 0); cycle("R10");
    idle(); upd(3, 0, 0); cycle("R10");
    idle(); req(0, 1'b1, 16); cycle("R10");
    // R7: drive posted counters around their range many times
    for (int i = 0; i < 300; i++) begin
      idle(); upd(0, pmod(cons[0] + 3, HM), pmod(cons[3] + 300, DM)); cycle("R9");
      idle(); req(0, 1'b1, 4096); cycle("R7");
      if (i % 50 == 7) begin
        idle(); upd(0, pmod(cons[0] + 1, HM), pmod(cons[3] + 255, DM)); cycle("R9");
        idle(); req(0, 1'b1, 4096); cycle("R7");
        req(0, 1'b1, 4080); cycle("R7");
      end
    end
    // R2: reload clears counters
    idle(); load(1, 1, 1, 1, 1, 1); cycle("R2");
    idle(); req(2, 1'b1, 16); cycle("R2");
    req(2, 1'b1, 16); cycle("R2");
    idle(); cycle("R6");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule